// File: doc/BRIEF.md
# NAND Prefetch and Write-Posting Engine

This block moves data between a host register port and a byte-wide NAND data port, in one direction per transfer. A 64-byte FIFO sits between the two sides. In read mode the engine pulls bytes from the NAND side ahead of the host, so the host finds them waiting. In write mode the host fills the FIFO with 32-bit words and the engine drains it to the NAND side one byte at a time. Raw NAND pin timing sits outside the block: the NAND side is a plain valid/ready byte handshake in each direction.

To run a transfer, the host sets a byte length, a direction and a FIFO threshold, then pulses start. While the transfer runs it watches two views. The first is a FIFO view: bytes available in read mode, free space in write mode, rounded down to whole words. The second is a remaining-byte count. A threshold event fires when the FIFO view crosses the threshold, and it also gives a one-cycle request pulse for a DMA engine. A completion event fires when the last byte has moved on the NAND side. Both events, a sticky overflow flag and a device-ready rise flag are kept in a status word. Each bit of that word is cleared by writing one to it. An abort input stops the engine at any time and makes it ready for the next start.

Top module: `nand_pfx_eng`

## Requirements
- R1: In read mode (direction 0) bytes taken on the NAND side reach the host in arrival order. In the host read word, bits 7:0 hold the oldest byte and bits 31:24 the newest. A word pops only when at least 4 bytes are stored. The engine never takes more bytes than the programmed length.
- R2: In read mode the engine deasserts its NAND ready while the FIFO holds 64 bytes. Fetching resumes once the host frees space.
- R3: In write mode (direction 1) each accepted host word leaves on the NAND side as four bytes, bits 7:0 first. No byte is offered unless a transfer is active with bytes still to go.
- R4: The FIFO count output shows stored bytes in read mode and free bytes in write mode, always rounded down to a multiple of 4. The view follows the direction of the last start.
- R5: At start the remaining count loads the programmed length. It drops by one for each byte handshake on the NAND side. On the handshake that takes it to zero, the engine goes idle and status bit 1 (completion) sets.
- R6: A start pulse while a transfer is active raises the busy-error output for one cycle. The running transfer's direction, count and FIFO contents stay as they were.
- R7: Status bit 0 sets, and the DMA request output pulses for one cycle, when the read fill or the write free space goes from below the latched threshold to at or above it. This is also checked in the first active cycle, so one event fires per crossing.
- R8: In write mode a host write that finds fewer than 4 free bytes is dropped, and status bit 4 (overflow) sets and stays set.
- R9: Status bit 8 sets on a rising edge of the device-ready input.
- R10: Writing 1 to a bit of the clear input clears that status bit. Bits written 0 keep their value. A set in the same cycle wins over the clear.
- R11: An abort pulse makes the engine idle, sets the remaining count to 0 and empties the FIFO. It leaves the status word alone.
- R12: The interrupt output is high when status bit 0 is set with its enable, or status bit 1 is set with its enable. Status bits 4 and 8 do not drive it.
- R13: A start with length 0 moves no data, leaves the engine idle and sets status bit 1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLen | input | LEN_W | Transfer length in bytes, sampled at start |
| cfgDir | input | 1 | 0 = read prefetch, 1 = write posting, sampled at start |
| cfgThr | input | CNT_W | FIFO threshold in bytes, sampled at start |
| startReq | input | 1 | Start pulse |
| abortReq | input | 1 | Stop and return to idle |
| fifoEvtEn | input | 1 | Interrupt enable for status bit 0 |
| doneEvtEn | input | 1 | Interrupt enable for status bit 1 |
| irqClr | input | 9 | Write-one-to-clear strobes for the status word |
| irqStatus | output | 9 | Status: bit 0 threshold, bit 1 complete, bit 4 overflow, bit 8 device ready |
| irq | output | 1 | Interrupt request |
| dmaReq | output | 1 | One-cycle pulse on each threshold event |
| busyErr | output | 1 | One-cycle pulse when a start is rejected |
| engActive | output | 1 | Transfer in progress |
| remaining | output | LEN_W | Bytes still to move on the NAND side |
| fifoCount | output | CNT_W | Available (read) or free (write) bytes, rounded to words |
| hostWrEn | input | 1 | Host word write strobe |
| hostWrData | input | 32 | Host write word |
| hostRdEn | input | 1 | Host word read strobe |
| hostRdData | output | 32 | Oldest stored word, valid while fifoCount is at least 4 |
| nandRdValid | input | 1 | NAND side offers a byte |
| nandRdData | input | 8 | Byte from NAND |
| nandRdReady | output | 1 | Engine takes the offered byte |
| nandWrValid | output | 1 | Engine offers a byte to NAND |
| nandWrData | output | 8 | Byte to NAND |
| nandWrReady | input | 1 | NAND side takes the byte |
| devRdy | input | 1 | Device-ready level |

## Verification
The hardest state to reach is the read-mode stall. The FIFO must sit at exactly 64 bytes while the transfer still has bytes left, and a second start must arrive in that state. The bench gets there by programming a length larger than the FIFO and holding off host reads until fetching stops. It then checks that the ready output is low and the remaining count is frozen, issues the rejected start while nothing moves, and finally drains the FIFO so fetching resumes. The write-side overflow is reached the same way: the NAND sink is held not ready while the host posts one word more than the FIFO holds.

// File: rtl/nand_pfx_pkg.sv
package nand_pfx_pkg;

  localparam int ST_W    = 9;
  localparam int ST_FIFO = 0;
  localparam int ST_DONE = 1;
  localparam int ST_OVF  = 4;
  localparam int ST_RDY  = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic nandPush;
    logic nandPop;
    logic hostPush;
    logic hostPop;
  } fifoCtl_t;

endpackage

// File: rtl/nand_pfx_dpath.sv
module nand_pfx_dpath
  import nand_pfx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int HOST_BYTES = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fifoCtl_t                ctl,
  input  logic [7:0]              nandByteIn,
  input  logic [8*HOST_BYTES-1:0] hostWordIn,
  output logic [CNT_W-1:0]        level,
  output logic [7:0]              headByte,
  output logic [8*HOST_BYTES-1:0] headWord
);

  localparam logic [CNT_W-1:0] HB_C  = CNT_W'(HOST_BYTES);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] lvlQ;
  logic [CNT_W-1:0] pushN;
  logic [CNT_W-1:0] popN;

  always_comb begin
    pushN = '0;
    if (ctl.hostPush)      pushN = HB_C;
    else if (ctl.nandPush) pushN = ONE_C;
    popN = '0;
    if (ctl.hostPop)       popN = HB_C;
    else if (ctl.nandPop)  popN = ONE_C;
  end

  always_ff @(posedge clk) begin
    if (ctl.hostPush) begin
      for (int i = 0; i < HOST_BYTES; i++)
        mem[wrPtr + PTR_W'(i)] <= hostWordIn[8*i +: 8];
    end else if (ctl.nandPush) begin
      mem[wrPtr] <= nandByteIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      lvlQ  <= '0;
    end else if (ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      lvlQ  <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(pushN);
      rdPtr <= rdPtr + PTR_W'(popN);
      lvlQ  <= lvlQ + pushN - popN;
    end
  end

  for (genvar g = 0; g < HOST_BYTES; g++) begin : gHead
    assign headWord[8*g +: 8] = mem[rdPtr + PTR_W'(g)];
  end

  assign headByte = mem[rdPtr];
  assign level    = lvlQ;

endmodule

// File: rtl/nand_pfx_ctrl.sv
module nand_pfx_ctrl
  import nand_pfx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 16,
  parameter int HOST_BYTES = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgDir,
  input  logic [CNT_W-1:0] cfgThr,
  input  logic             startReq,
  input  logic             abortReq,
  input  logic             fifoEvtEn,
  input  logic             doneEvtEn,
  input  logic [ST_W-1:0]  irqClr,
  input  logic             hostWrEn,
  input  logic             hostRdEn,
  input  logic             nandRdValid,
  input  logic             nandWrReady,
  input  logic             devRdy,
  input  logic [CNT_W-1:0] level,
  output fifoCtl_t         ctl,
  output logic             nandRdReady,
  output logic             nandWrValid,
  output logic [ST_W-1:0]  irqStatus,
  output logic             irq,
  output logic             dmaReq,
  output logic             busyErr,
  output logic             engActive,
  output logic [LEN_W-1:0] remaining,
  output logic [CNT_W-1:0] fifoCount
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HB_C    = CNT_W'(HOST_BYTES);
  localparam logic [LEN_W-1:0] LAST_C  = LEN_W'(1);

  logic             activeQ;
  logic             dirQ;
  logic             prevMet;
  logic             prevRdy;
  logic [CNT_W-1:0] thrQ;
  logic [LEN_W-1:0] remQ;
  logic [ST_W-1:0]  stQ;

  logic [CNT_W-1:0] freeSp;
  logic [CNT_W-1:0] viewRaw;
  logic             startOk;
  logic             rdTake;
  logic             wrGive;
  logic             xfer;
  logic             wrSel;
  logic             hostFits;
  logic             thrMet;
  logic             fifoEvt;
  logic             doneEvt;
  logic             ovfHit;
  logic             rdyRise;
  logic [ST_W-1:0]  stSet;

  always_comb begin
    freeSp  = DEPTH_C - level;
    startOk = startReq & ~activeQ & ~abortReq;

    nandRdReady = activeQ & ~dirQ & ~abortReq & (level != DEPTH_C) & (remQ != '0);
    nandWrValid = activeQ & dirQ & ~abortReq & (level != '0) & (remQ != '0);
    rdTake = nandRdValid & nandRdReady;
    wrGive = nandWrValid & nandWrReady;
    xfer   = rdTake | wrGive;

    wrSel    = hostWrEn & activeQ & dirQ & ~abortReq;
    hostFits = freeSp >= HB_C;
    ovfHit   = wrSel & ~hostFits;

    ctl.flush    = abortReq | startOk;
    ctl.nandPush = rdTake;
    ctl.nandPop  = wrGive;
    ctl.hostPush = wrSel & hostFits;
    ctl.hostPop  = hostRdEn & ~dirQ & (level >= HB_C) & ~ctl.flush;

    thrMet  = dirQ ? (freeSp >= thrQ) : (level >= thrQ);
    fifoEvt = activeQ & ~abortReq & thrMet & ~prevMet;
    doneEvt = (xfer & (remQ == LAST_C)) | (startOk & (cfgLen == '0));
    rdyRise = devRdy & ~prevRdy;

    stSet          = '0;
    stSet[ST_FIFO] = fifoEvt;
    stSet[ST_DONE] = doneEvt;
    stSet[ST_OVF]  = ovfHit;
    stSet[ST_RDY]  = rdyRise;

    viewRaw   = dirQ ? freeSp : level;
    fifoCount = (viewRaw / HB_C) * HB_C;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      dirQ    <= 1'b0;
      thrQ    <= '0;
      remQ    <= '0;
      stQ     <= '0;
      prevMet <= 1'b0;
      prevRdy <= 1'b1;
      busyErr <= 1'b0;
      dmaReq  <= 1'b0;
    end else begin
      stQ     <= (stQ & ~irqClr) | stSet;
      prevMet <= activeQ & ~abortReq & thrMet;
      prevRdy <= devRdy;
      busyErr <= startReq & activeQ & ~abortReq;
      dmaReq  <= fifoEvt;
      if (abortReq) begin
        activeQ <= 1'b0;
        remQ    <= '0;
      end else if (startOk) begin
        dirQ <= cfgDir;
        thrQ <= cfgThr;
        remQ <= cfgLen;
        activeQ <= (cfgLen != '0);
      end else if (xfer) begin
        remQ <= remQ - LAST_C;
        if (remQ == LAST_C) activeQ <= 1'b0;
      end
    end
  end

  assign irqStatus = stQ;
  assign irq       = (stQ[ST_FIFO] & fifoEvtEn) | (stQ[ST_DONE] & doneEvtEn);
  assign engActive = activeQ;
  assign remaining = remQ;

endmodule

// File: rtl/nand_pfx_eng.sv
module nand_pfx_eng
  import nand_pfx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 16,
  localparam int HOST_BYTES = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgDir,
  input  logic [CNT_W-1:0] cfgThr,
  input  logic             startReq,
  input  logic             abortReq,
  input  logic             fifoEvtEn,
  input  logic             doneEvtEn,
  input  logic [8:0]       irqClr,
  output logic [8:0]       irqStatus,
  output logic             irq,
  output logic             dmaReq,
  output logic             busyErr,
  output logic             engActive,
  output logic [LEN_W-1:0] remaining,
  output logic [CNT_W-1:0] fifoCount,
  input  logic             hostWrEn,
  input  logic [31:0]      hostWrData,
  input  logic             hostRdEn,
  output logic [31:0]      hostRdData,
  input  logic             nandRdValid,
  input  logic [7:0]       nandRdData,
  output logic             nandRdReady,
  output logic             nandWrValid,
  output logic [7:0]       nandWrData,
  input  logic             nandWrReady,
  input  logic             devRdy
);

  fifoCtl_t         ctl;
  logic [CNT_W-1:0] level;

  nand_pfx_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .HOST_BYTES(HOST_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgLen(cfgLen), .cfgDir(cfgDir), .cfgThr(cfgThr),
    .startReq(startReq), .abortReq(abortReq),
    .fifoEvtEn(fifoEvtEn), .doneEvtEn(doneEvtEn), .irqClr(irqClr),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .nandRdValid(nandRdValid), .nandWrReady(nandWrReady), .devRdy(devRdy),
    .level(level), .ctl(ctl),
    .nandRdReady(nandRdReady), .nandWrValid(nandWrValid),
    .irqStatus(irqStatus), .irq(irq), .dmaReq(dmaReq), .busyErr(busyErr),
    .engActive(engActive), .remaining(remaining), .fifoCount(fifoCount)
  );

  nand_pfx_dpath #(.DEPTH(DEPTH), .HOST_BYTES(HOST_BYTES)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .nandByteIn(nandRdData), .hostWordIn(hostWrData),
    .level(level), .headByte(nandWrData), .headWord(hostRdData)
  );

endmodule

// File: rtl/nand_pfx_chk.sv
module nand_pfx_chk #(
  parameter int DEPTH = 64,
  parameter int LEN_W = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic             abortReq,
  input logic             engActive,
  input logic             busyErr,
  input logic [LEN_W-1:0] remaining,
  input logic             nandRdValid,
  input logic             nandRdReady,
  input logic             nandWrValid,
  input logic             nandWrReady,
  input logic [CNT_W-1:0] fifoCount,
  input logic             dmaReq,
  input logic [8:0]       irqStatus
);

  logic nandXfer;
  assign nandXfer = (nandRdValid & nandRdReady) | (nandWrValid & nandWrReady);

  // R6
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    engActive && startReq && !abortReq |=> busyErr);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    engActive && startReq && !abortReq && !nandXfer |=> remaining == $past(remaining));

  // R2
  fifo_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    nandRdReady |-> fifoCount != CNT_W'(DEPTH));

  // R1
  no_overfetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    nandRdReady |-> remaining != '0);

  // R3
  wr_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    nandWrValid |-> engActive && remaining != '0);

  // R4
  word_gran_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount[1:0] == 2'b00);

  // R7
  dma_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> irqStatus[0]);

  // R5
  done_chk: assert property (@(posedge clk) disable iff (!rstN)
    engActive && remaining == LEN_W'(1) && nandXfer && !abortReq
    |=> !engActive && irqStatus[1] && remaining == '0);

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !engActive && remaining == '0);

endmodule

bind nand_pfx_eng nand_pfx_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/nand_pfx_eng_tb_top.sv
module nand_pfx_eng_tb_top;

  localparam int DEPTH = 64;
  localparam int LEN_W = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [LEN_W-1:0] cfgLen = '0;
  logic             cfgDir = 1'b0;
  logic [CNT_W-1:0] cfgThr = '0;
  logic             startReq = 1'b0;
  logic             abortReq = 1'b0;
  logic             fifoEvtEn = 1'b1;
  logic             doneEvtEn = 1'b1;
  logic [8:0]       irqClr = '0;
  logic [8:0]       irqStatus;
  logic             irq;
  logic             dmaReq;
  logic             busyErr;
  logic             engActive;
  logic [LEN_W-1:0] remaining;
  logic [CNT_W-1:0] fifoCount;
  logic             hostWrEn = 1'b0;
  logic [31:0]      hostWrData = '0;
  logic             hostRdEn = 1'b0;
  logic [31:0]      hostRdData;
  logic             nandRdValid = 1'b0;
  logic [7:0]       nandRdData = 8'h11;
  logic             nandRdReady;
  logic             nandWrValid;
  logic [7:0]       nandWrData;
  logic             nandWrReady = 1'b0;
  logic             devRdy = 1'b0;

  nand_pfx_eng #(.DEPTH(DEPTH), .LEN_W(LEN_W)) dut_i (.*);

  always #5 clk = ~clk;

  int nChk = 0;
  int nFail = 0;
  int dmaCount = 0;
  bit tookRd = 0;
  logic [7:0] expQ[$];

  task automatic chkEq(input string req, input string what, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  // monitor: records fetched bytes, compares posted bytes
  always @(negedge clk) begin
    if (rstN) begin
      if (dmaReq) dmaCount++;
      if (nandRdValid && nandRdReady) begin
        expQ.push_back(nandRdData);
        tookRd = 1;
      end
      if (nandWrValid && nandWrReady) begin
        if (expQ.size() == 0) chkEq("R3", "unexpected nand byte", nandWrData, 0);
        else chkEq("R3", "nand write byte", nandWrData, expQ.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    if (tookRd) begin
      nandRdData <= nandRdData + 8'd37;
      tookRd = 0;
    end
  end

  task automatic startXfer(input int len, input bit dir, input int thr);
    @(posedge clk); #1;
    cfgLen = LEN_W'(len); cfgDir = dir; cfgThr = CNT_W'(thr); startReq = 1'b1;
    @(posedge clk); #1;
    startReq = 1'b0;
  endtask

  task automatic hostRead();
    logic [31:0] expW;
    forever begin
      @(negedge clk);
      if (fifoCount >= 4) break;
    end
    @(posedge clk); #1;
    hostRdEn = 1'b1;
    @(negedge clk);
    for (int b = 0; b < 4; b++) expW[8*b +: 8] = expQ.pop_front();
    chkEq("R1", "host read word", hostRdData, expW);
    @(posedge clk); #1;
    hostRdEn = 1'b0;
  endtask

  task automatic hostWrite(input logic [31:0] w, input bit accepted);
    @(posedge clk); #1;
    hostWrEn = 1'b1; hostWrData = w;
    if (accepted) for (int b = 0; b < 4; b++) expQ.push_back(w[8*b +: 8]);
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic clearAll(input logic [8:0] m);
    @(posedge clk); #1;
    irqClr = m;
    @(posedge clk); #1;
    irqClr = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chkEq("R5", "reset remaining", remaining, 0);
    chkEq("R4", "reset fifo count", fifoCount, 0);
    chkEq("R10", "reset status", irqStatus, 0);
    chkEq("R5", "reset active", engActive, 0);

    // read prefetch, short length
    nandRdValid = 1'b1;
    dmaCount = 0;
    startXfer(20, 1'b0, 8);
    repeat (40) @(negedge clk);
    chkEq("R5", "read done remaining", remaining, 0);
    chkEq("R5", "read done idle", engActive, 0);
    chkEq("R5", "read done status", irqStatus[1], 1);
    chkEq("R7", "read threshold status", irqStatus[0], 1);
    chkEq("R7", "one dma pulse", dmaCount, 1);
    chkEq("R12", "irq with enables", irq, 1);
    chkEq("R4", "read fill view", fifoCount, 20);
    chkEq("R1", "fetched no more than length", expQ.size(), 20);
    for (int k = 0; k < 5; k++) hostRead();
    @(negedge clk);
    chkEq("R4", "read fifo empty", fifoCount, 0);
    clearAll(9'h1FF);
    @(negedge clk);
    chkEq("R10", "clear all", irqStatus, 0);
    chkEq("R12", "irq low after clear", irq, 0);

    // read prefetch longer than FIFO: stall, busy reject, drain
    startXfer(100, 1'b0, 8);
    repeat (90) @(negedge clk);
    chkEq("R2", "fifo full count", fifoCount, 64);
    chkEq("R2", "ready low when full", nandRdReady, 0);
    chkEq("R2", "remaining frozen", remaining, 36);
    @(posedge clk); #1;
    cfgLen = 16'd5; startReq = 1'b1;
    @(posedge clk); #1;
    startReq = 1'b0;
    @(negedge clk);
    chkEq("R6", "busy error", busyErr, 1);
    chkEq("R6", "remaining kept", remaining, 36);
    chkEq("R6", "still active", engActive, 1);
    @(negedge clk);
    chkEq("R6", "busy one cycle", busyErr, 0);
    for (int k = 0; k < 25; k++) hostRead();
    repeat (5) @(negedge clk);
    chkEq("R2", "long read done", irqStatus[1], 1);
    chkEq("R1", "queue drained", expQ.size(), 0);
    nandRdValid = 1'b0;
    clearAll(9'h1FF);

    // write posting
    startXfer(12, 1'b1, 24);
    repeat (2) @(negedge clk);
    chkEq("R4", "write free view", fifoCount, 64);
    chkEq("R7", "write threshold at start", irqStatus[0], 1);
    hostWrite(32'h44332211, 1'b1);
    hostWrite(32'h88776655, 1'b1);
    hostWrite(32'hCCBBAA99, 1'b1);
    @(negedge clk);
    chkEq("R4", "write free after 12", fifoCount, 52);
    chkEq("R3", "no output while sink stalled", expQ.size(), 12);
    @(posedge clk); #1;
    nandWrReady = 1'b1;
    repeat (20) @(negedge clk);
    chkEq("R5", "write done remaining", remaining, 0);
    chkEq("R5", "write done status", irqStatus[1], 1);
    chkEq("R3", "all bytes posted", expQ.size(), 0);
    chkEq("R3", "valid low when idle", nandWrValid, 0);
    @(posedge clk); #1;
    nandWrReady = 1'b0;
    clearAll(9'h1FF);

    // overflow, partial clear, abort
    startXfer(100, 1'b1, 24);
    for (int k = 0; k < 16; k++) hostWrite(32'h0A0B0C00 + k, 1'b1);
    hostWrite(32'hDEADBEEF, 1'b0);
    @(negedge clk);
    chkEq("R8", "overflow flag", irqStatus[4], 1);
    chkEq("R8", "fifo full free view", fifoCount, 0);
    clearAll(9'h010);
    @(negedge clk);
    chkEq("R10", "overflow cleared", irqStatus[4], 0);
    chkEq("R10", "threshold bit kept", irqStatus[0], 1);
    @(posedge clk); #1;
    abortReq = 1'b1;
    @(posedge clk); #1;
    abortReq = 1'b0;
    expQ.delete();
    @(negedge clk);
    chkEq("R11", "abort idle", engActive, 0);
    chkEq("R11", "abort remaining", remaining, 0);
    chkEq("R11", "abort flushed", fifoCount, 64);
    chkEq("R11", "abort keeps status", irqStatus[0], 1);
    @(posedge clk); #1;
    nandWrReady = 1'b1;
    repeat (5) @(negedge clk);
    chkEq("R11", "no output after abort", nandWrValid, 0);
    @(posedge clk); #1;
    nandWrReady = 1'b0;
    clearAll(9'h1FF);

    // device ready rise
    @(posedge clk); #1;
    devRdy = 1'b1;
    repeat (2) @(negedge clk);
    chkEq("R9", "device ready flag", irqStatus[8], 1);
    chkEq("R12", "ready flag no irq", irq, 0);
    clearAll(9'h100);
    @(negedge clk);
    chkEq("R9", "ready flag cleared, level held", irqStatus[8], 0);

    // zero length
    startXfer(0, 1'b0, 8);
    @(negedge clk);
    chkEq("R13", "zero length done", irqStatus[1], 1);
    chkEq("R13", "zero length idle", engActive, 0);
    chkEq("R13", "zero length no data", fifoCount, 0);

    // interrupt enables
    @(posedge clk); #1;
    doneEvtEn = 1'b0; fifoEvtEn = 1'b0;
    @(negedge clk);
    chkEq("R12", "irq masked", irq, 0);
    @(posedge clk); #1;
    doneEvtEn = 1'b1;
    @(negedge clk);
    chkEq("R12", "irq unmasked", irq, 1);

    summary();
    $finish;
  end

endmodule